// File: doc/BRIEF.md
# Multi-mode 16-bit timer counter core

This block is the counting heart of a general-purpose timer. A single clock-enable input, `tick_en`, stands in for whatever clock source the surrounding logic selects. A prescaler divides those ticks by 1, 2, 4 or 8. Each divided tick, called a step here, advances a 16-bit counter according to a 2-bit run mode: halted, counting up to a period value, free-running across the full 16-bit range, or sweeping up to the period value and back down to zero as a triangle.

Every mode that counts has one wrap point, and reaching it sets a sticky overflow flag. An enable bit gates that flag onto the interrupt request line. A one-cycle match strobe tells neighbouring compare channels that the count has just landed on the period value. A clear strobe restarts the count, the prescaler phase and the direction together. Software lowers the overflow flag with a separate clear input.

No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control and status levels or single-cycle strobes, sampled on the rising clock edge.

Top module: `mtimer_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `count` is 0, `dir_down` is 0, and `equ_pulse`, `ovf_flag` and `irq` are all 0.
- R2: With `run_mode` = 2'b00 (halt), ticks have no effect. The count, the direction and the prescaler phase all keep their values, so counting resumes exactly where it stopped.
- R3: With `run_mode` = 2'b01 (up), each step adds 1 until the count equals `period`. The next step loads 0 and sets `ovf_flag`. A count above `period` also wraps to 0 on its next step.
- R4: With `run_mode` = 2'b10 (free-run), each step adds 1. The step taken at 0xFFFF loads 0 and sets `ovf_flag`.
- R5: With `run_mode` = 2'b11 (triangle), the count rises by 1 per step. `dir_down` goes to 1 on the step that makes the count equal to `period`. The count then falls by 1 per step. The step that reaches 0 sets `ovf_flag` and returns `dir_down` to 0. For a period P of 1 or more, the pattern repeats every 2P steps.
- R6: `div_code` values 2'b00, 2'b01, 2'b10 and 2'b11 make one step for every 1, 2, 4 and 8 cycles in which `tick_en` is high. Cycles with `tick_en` low are not counted.
- R7: A `clr_stb` cycle zeroes `count`, `dir_down` and the prescaler phase at the next edge, whatever the mode and tick. It does not change `ovf_flag`.
- R8: `equ_pulse` is high for one cycle, from the edge at which a step loads a count equal to `period`. It stays low in every cycle that no such step preceded.
- R9: `ovf_flag` stays at 1 until a cycle with `flag_clr` high. A wrap in that same cycle keeps it at 1.
- R10: `irq` equals `ovf_flag` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counting-clock enable from the selected source |
| run_mode | input | 2 | 00 halt, 01 up, 10 free-run, 11 triangle |
| div_code | input | 2 | Prescaler: 00 /1, 01 /2, 10 /4, 11 /8 |
| clr_stb | input | 1 | One-cycle restart of count, direction and prescaler |
| flag_clr | input | 1 | Lowers the overflow flag |
| irq_en | input | 1 | Gates the overflow flag onto `irq` |
| period | input | 16 | Period value shared with compare register 0 |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | 1 while the triangle mode counts down |
| equ_pulse | output | 1 | One-cycle strobe when the count lands on `period` |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
`count`, `dir_down`, `ovf_flag` and `equ_pulse` all change at the same rising edge: the one that consumes the divider's last tick, or the one after a `clr_stb` cycle. `irq` follows `ovf_flag` with no extra register. The bench drives every input just after a falling edge and samples all outputs at the next falling edge, so each sample reflects exactly the ticks applied so far. From the number of accepted ticks, the bench works out the number of steps arithmetically, and from that the count, direction, wrap count and match strobe. The sweep covers up and triangle modes with every divider code, several periods, continuous and gated tick patterns, and one complete 65536-step free-run wrap.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef enum logic [1:0] {
    RUN_HALT = 2'b00,
    RUN_UP   = 2'b01,
    RUN_FREE = 2'b10,
    RUN_TRI  = 2'b11
  } run_mode_e;

endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             tick_en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             step
);
  // the largest ratio is 2**(2**DIV_W - 1), so the phase needs 2**DIV_W - 1 bits
  localparam int PH_W = (1 << DIV_W) - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last_ph;

  // last_ph holds div_sel ones in its low bits: the final phase of one step period
  always_comb begin
    for (int i = 0; i < PH_W; i++) begin
      last_ph[i] = (i < int'(div_sel));
    end
  end

  assign step = tick_en && !hold && !clr && (phase >= last_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clr) begin
      phase <= '0;
    end else if (tick_en && !hold) begin
      if (phase >= last_ph) phase <= '0;
      else                  phase <= phase + 1'b1;
    end
  end

  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div_sel != '0) |=> (!step || div_sel == '0)) else $error("step spacing"); // R6

endmodule

// File: rtl/mtimer_count.sv
module mtimer_count
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  run_mode_e        mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             wrap_now,
  output logic             equ
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP  = '1;

  logic [CNT_W-1:0] nxt;
  logic             nxt_dir;
  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] dec;

  assign inc = count + ONE;
  assign dec = count - ONE;

  always_comb begin
    nxt      = count;
    nxt_dir  = dir_down;
    wrap_now = 1'b0;
    if (step) begin
      unique case (mode)
        RUN_UP: begin
          if (count >= period) begin
            nxt      = ZERO;
            wrap_now = 1'b1;
          end else begin
            nxt = inc;
          end
        end
        RUN_FREE: begin
          if (count == TOP) begin
            nxt      = ZERO;
            wrap_now = 1'b1;
          end else begin
            nxt = inc;
          end
        end
        RUN_TRI: begin
          if (!dir_down) begin
            if (count >= period) begin
              // at or above the turning point: start the descent
              if (count != ZERO) begin
                nxt     = dec;
                nxt_dir = 1'b1;
              end
            end else begin
              nxt = inc;
              if (inc >= period) nxt_dir = 1'b1;
            end
          end else begin
            if (count <= ONE) begin
              nxt      = ZERO;
              nxt_dir  = 1'b0;
              wrap_now = 1'b1;
            end else begin
              nxt = dec;
            end
          end
        end
        default: begin
          nxt = count;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= ZERO;
      dir_down <= 1'b0;
      equ      <= 1'b0;
    end else if (clr) begin
      count    <= ZERO;
      dir_down <= 1'b0;
      equ      <= 1'b0;
    end else begin
      count    <= nxt;
      dir_down <= nxt_dir;
      equ      <= step && (nxt == period);
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_HALT && !clr) |=> ($stable(count) && $stable(dir_down))) else $error("halt"); // R2
  AST_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_UP && count <= period) |=> (count <= $past(period))) else $error("up bound"); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now |=> (count == ZERO)) else $error("wrap"); // R4
  AST_TRI_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_TRI && dir_down && wrap_now) |=> !dir_down) else $error("turn"); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == ZERO && !dir_down && !equ)) else $error("clear"); // R7
  AST_EQU_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    equ |-> (count == $past(period))) else $error("equ"); // R8

endmodule

// File: rtl/mtimer_ovf.sv
module mtimer_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wipe,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  // a wrap beats a simultaneous software clear, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (wipe) flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wipe) |=> flag) else $error("sticky"); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag) else $error("set wins"); // R9

endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
  import mtimer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [1:0]       run_mode,
  input  logic [DIV_W-1:0] div_code,
  input  logic             clr_stb,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             equ_pulse,
  output logic             ovf_flag,
  output logic             irq
);
  run_mode_e mode_e;
  logic      step;
  logic      wrap_now;

  assign mode_e = run_mode_e'(run_mode);

  mtimer_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_stb),
    .hold    (mode_e == RUN_HALT),
    .tick_en (tick_en),
    .div_sel (div_code),
    .step    (step)
  );

  mtimer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_stb),
    .step     (step),
    .mode     (mode_e),
    .period   (period),
    .count    (count),
    .dir_down (dir_down),
    .wrap_now (wrap_now),
    .equ      (equ_pulse)
  );

  mtimer_ovf u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (wrap_now),
    .wipe   (flag_clr),
    .irq_en (irq_en),
    .flag   (ovf_flag),
    .irq    (irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !ovf_flag)) else $error("reset"); // R1

endmodule

// File: tb/mtimer_core_test.sv
`timescale 1ns/1ps
module mtimer_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  run_mode = 2'b00;
  logic [1:0]  div_code = 2'b00;
  logic        clr_stb = 1'b0;
  logic        flag_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] period = 16'd0;
  logic [15:0] count;
  logic        dir_down, equ_pulse, ovf_flag, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtimer_core uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_mode(run_mode),
    .div_code(div_code), .clr_stb(clr_stb), .flag_clr(flag_clr), .irq_en(irq_en),
    .period(period), .count(count), .dir_down(dir_down), .equ_pulse(equ_pulse),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // restart count, phase and flag; leaves the bench sampled after the clear edge
  task automatic restart(input logic [1:0] m, input logic [1:0] d, input int p, input logic ien);
    @(negedge clk);
    run_mode = m; div_code = d; period = 16'(p); irq_en = ien;
    tick_en = 1'b0; clr_stb = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    chk("R7 count after clear", int'(count), 0);
    chk("R7 dir after clear", int'(dir_down), 0);
    clr_stb = 1'b0; flag_clr = 1'b0;
  endtask

  // sweep one configuration; expected state from the accepted tick count
  task automatic sweep(input int m, input int d, input int p, input int ncyc,
                       input bit gated, input bit ien);
    int ticks = 0;
    int dv = 1 << d;
    string tag;
    restart(2'(m), 2'(d), p, ien);
    tag = (m == 1) ? "R3/R6" : (m == 2) ? "R4/R6" : "R5/R6";
    for (int c = 0; c < ncyc; c++) begin
      int n, ec, ed, ew, k;
      bit t, stepped;
      t = gated ? (((c * 7 + 3) % 5) != 0) : 1'b1;
      tick_en = t;
      stepped = t && (((ticks + 1) % dv) == 0);
      if (t) ticks++;
      @(negedge clk);
      n = ticks / dv;
      if (m == 1) begin
        ec = n % (p + 1); ed = 0; ew = n / (p + 1);
      end else if (m == 2) begin
        ec = n % 65536; ed = 0; ew = n / 65536;
      end else begin
        k = n % (2 * p);
        ec = (k <= p) ? k : 2 * p - k;
        ed = (k >= p) ? 1 : 0;
        ew = n / (2 * p);
      end
      chk(tag, int'(count), ec);
      chk("R5 direction", int'(dir_down), ed);
      chk("R8 equ strobe", int'(equ_pulse), (stepped && ec == p) ? 1 : 0);
      chk("R3/R4/R5 overflow flag", int'(ovf_flag), (ew > 0) ? 1 : 0);
      chk("R10 irq", int'(irq), (ew > 0 && ien) ? 1 : 0);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", int'(count), 0);
    chk("R1 flag in reset", int'(ovf_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dir_down), 0);
    chk("R1 equ", int'(equ_pulse), 0);
    chk("R1 flag", int'(ovf_flag), 0);
    chk("R1 irq", int'(irq), 0);

    // up and triangle modes, every divider, several periods
    for (int m = 1; m <= 3; m += 2) begin
      for (int d = 0; d < 4; d++) begin
        for (int pi = 0; pi < 3; pi++) begin
          int p = (pi == 0) ? 1 : (pi == 1) ? 3 : 6;
          sweep(m, d, p, (2 * p + 2) * 3 * (1 << d) + 4, (d + pi) % 2 == 1, pi != 1);
        end
      end
    end
    sweep(1, 0, 0, 12, 1'b0, 1'b1);          // R3 zero period wraps on every step
    sweep(1, 2, 9, 150, 1'b1, 1'b1);         // R6 gated ticks, divide by 4
    sweep(2, 1, 100, 300, 1'b0, 1'b1);       // R4 free-run with divider
    sweep(2, 0, 100, 65540, 1'b0, 1'b1);     // R4 full wrap at 0xFFFF

    // R2: halt keeps count, direction and prescaler phase
    restart(2'b01, 2'b01, 50, 1'b0);
    for (int c = 0; c < 5; c++) begin tick_en = 1'b1; @(negedge clk); end
    chk("R6 two steps from five ticks", int'(count), 2);
    run_mode = 2'b00;
    for (int c = 0; c < 10; c++) begin tick_en = 1'b1; @(negedge clk); end
    chk("R2 halt holds count", int'(count), 2);
    chk("R2 halt no flag", int'(ovf_flag), 0);
    run_mode = 2'b01; tick_en = 1'b1;
    @(negedge clk);
    chk("R2 phase kept across halt", int'(count), 3);
    tick_en = 1'b0;

    restart(2'b11, 2'b00, 4, 1'b0);
    for (int c = 0; c < 5; c++) begin tick_en = 1'b1; @(negedge clk); end
    run_mode = 2'b00;
    for (int c = 0; c < 6; c++) begin tick_en = 1'b1; @(negedge clk); end
    chk("R2 halt holds triangle count", int'(count), 3);
    chk("R2 halt holds direction", int'(dir_down), 1);
    tick_en = 1'b0;

    // R7/R9: clear strobe leaves the flag; flag_clr lowers it
    restart(2'b01, 2'b00, 2, 1'b1);
    for (int c = 0; c < 4; c++) begin tick_en = 1'b1; @(negedge clk); end
    chk("R3 flag after wrap", int'(ovf_flag), 1);
    tick_en = 1'b0; clr_stb = 1'b1;
    @(negedge clk);
    clr_stb = 1'b0;
    chk("R7 count zeroed", int'(count), 0);
    chk("R7 flag untouched by clear", int'(ovf_flag), 1);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", int'(ovf_flag), 1);
    chk("R10 irq with flag", int'(irq), 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R10 irq masked", int'(irq), 0);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R9 flag lowered", int'(ovf_flag), 0);

    // R9: wrap in the same cycle as flag_clr keeps the flag
    restart(2'b01, 2'b00, 0, 1'b1);
    tick_en = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; flag_clr = 1'b0;
    chk("R9 wrap beats flag clear", int'(ovf_flag), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule